// File: doc/BRIEF.md
# Serial Shifter with Selectable Clocking

This block is a general-purpose serial interface engine. An 8-bit data register shifts in one bit from the serial data pin on each shift event, most significant bit first. Its top bit drives the serial data output. A 4-bit edge counter runs beside it and raises an overflow flag when it wraps. Software or a protocol layer can then take over at byte or bit boundaries. A control word selects the clock for each of the two parts independently. The choices are no clock, a software strobe, a timer compare-match pulse, or the external serial clock pin. For the pin, the shifter acts on one chosen edge. The counter acts on both edges, or on a separate software toggle strobe.

While overflow is pending and the hold enable is set, the block asserts a clock-hold output that keeps the serial clock line low. A start detector sets a flag when the data line falls while the clock line is high, and it zeroes the counter. Both pins pass through a synchronizer into the system clock domain. All register writes are single-cycle strobes on three write ports: control, status and data.

Top module: `serx_core`

## Requirements
- R1: After reset the data register, counter, overflow flag, start flag and clock-hold output are all 0. The control word is 0, which means source none.
- R2: Control word layout: bits [1:0] are the source select (00 none, 01 timer, 10 external rising, 11 external falling), bit 2 is the strobe mode, bit 3 is the shift strobe, bit 4 is the count toggle and bit 5 is the hold enable. With select 00 and strobe mode 0, pin edges, timer pulses and strobes change neither the data register nor the counter.
- R3: With select 00 and strobe mode 1, each control write carrying bit 3 shifts the data register once and adds 1 to the counter.
- R4: With select 01, each timer pulse shifts the data register once and adds 1 to the counter, whatever the strobe mode. Control bit 3 has no effect in this mode.
- R5: With select 10 and strobe mode 0, a rising edge of the synchronized clock pin shifts the data register. Both edges of the pin add 1 to the counter.
- R6: With select 11 and strobe mode 0, only a falling edge of the clock pin shifts the data register. Both edges add 1 to the counter.
- R7: With select 10 or 11 and strobe mode 1, shifting still follows the chosen pin edge. The counter ignores pin edges and advances only on control writes carrying bit 4.
- R8: A status write loads the counter from status bits [3:0].
- R9: When the counter wraps from 15 to 0, the overflow flag sets. It clears only on a status write with bit 4 set.
- R10: The clock-hold output is high exactly while the overflow flag and the hold enable are both set.
- R11: A shift moves the register left by one bit and takes the synchronized data pin into bit 0. Bit 7 drives the serial data output. A data write loads the register directly.
- R12: A fall of the synchronized data pin while the synchronized clock pin is high sets the start flag and clears the counter. A status write with bit 5 set clears the start flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_pin_i | input | 1 | Serial data pin (asynchronous) |
| scl_pin_i | input | 1 | Serial clock pin (asynchronous) |
| tmr_match_i | input | 1 | Timer compare-match pulse, one cycle |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 6 | Control word write data |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 6 | Status write data (preload, flag clears) |
| dat_wr_i | input | 1 | Data register write strobe |
| dat_wdata_i | input | 8 | Data register write data |
| sdo_o | output | 1 | Serial data out, register MSB |
| scl_hold_o | output | 1 | Hold serial clock low |
| ovf_o | output | 1 | Counter overflow flag |
| start_o | output | 1 | Start condition flag |
| cnt_o | output | 4 | Edge counter value |
| dat_o | output | 8 | Data register value |

## Verification
The bench builds the block with its defaults: an 8-bit data register, a 4-bit counter and a two-stage synchronizer. The counter is only four bits wide, so a preload of 14 followed by two events reaches the wrap, the overflow flag and the clock hold within a few cycles. The two-stage synchronizer gives a fixed latency of a few cycles from a pin change to its effect, so every pin-driven scenario can wait a known number of cycles before it compares the register and counter.

// File: rtl/serx_pkg.sv
package serx_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'b00,
    SRC_TIMER   = 2'b01,
    SRC_EXT_POS = 2'b10,
    SRC_EXT_NEG = 2'b11
  } src_e;

  typedef struct packed {
    logic hold_en;
    logic strb;
    src_e src;
  } mode_t;

  localparam int CTL_W        = 6;
  localparam int CTL_STRB_BIT = 2;
  localparam int CTL_SHOT_BIT = 3;
  localparam int CTL_TOG_BIT  = 4;
  localparam int CTL_HOLD_BIT = 5;
endpackage

// File: rtl/serx_sync.sv
module serx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/serx_clk_sel.sv
module serx_clk_sel
  import serx_pkg::*;
(
  input  mode_t mode_i,
  input  logic  ext_rise_i,
  input  logic  ext_fall_i,
  input  logic  tmr_i,
  input  logic  shot_i,
  input  logic  tog_i,
  output logic  shift_en_o,
  output logic  count_en_o
);
  always_comb begin
    shift_en_o = 1'b0;
    count_en_o = 1'b0;
    unique case (mode_i.src)
      SRC_NONE: begin
        shift_en_o = mode_i.strb & shot_i;
        count_en_o = mode_i.strb & shot_i;
      end
      SRC_TIMER: begin
        shift_en_o = tmr_i;
        count_en_o = tmr_i;
      end
      SRC_EXT_POS: begin
        shift_en_o = ext_rise_i;
        count_en_o = mode_i.strb ? tog_i : (ext_rise_i | ext_fall_i);
      end
      SRC_EXT_NEG: begin
        shift_en_o = ext_fall_i;
        count_en_o = mode_i.strb ? tog_i : (ext_rise_i | ext_fall_i);
      end
      default: begin
        shift_en_o = 1'b0;
        count_en_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/serx_shifter.sv
module serx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= '0;
    else if (load_i)  sr_q <= load_data_i;
    else if (shift_i) sr_q <= {sr_q[DATA_W-2:0], sdi_i};
  end

  assign data_o = sr_q;
  assign sdo_o  = sr_q[DATA_W-1];
endmodule

// File: rtl/serx_counter.sv
module serx_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = step_i & ~clear_i & ~load_i & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             ovf_q <= 1'b0;
    else if (wrap)       ovf_q <= 1'b1;
    else if (flag_clr_i) ovf_q <= 1'b0;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/serx_core.sv
module serx_core
  import serx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sda_pin_i,
  input  logic                 scl_pin_i,
  input  logic                 tmr_match_i,
  input  logic                 ctl_wr_i,
  input  logic [CTL_W-1:0]     ctl_wdata_i,
  input  logic                 stat_wr_i,
  input  logic [CNT_W+1:0]     stat_wdata_i,
  input  logic                 dat_wr_i,
  input  logic [DATA_W-1:0]    dat_wdata_i,
  output logic                 sdo_o,
  output logic                 scl_hold_o,
  output logic                 ovf_o,
  output logic                 start_o,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [DATA_W-1:0]    dat_o
);
  localparam int OVF_CLR_BIT   = CNT_W;
  localparam int START_CLR_BIT = CNT_W + 1;

  mode_t mode_q;
  logic  start_q;
  logic  sda_s, sda_rise, sda_fall;
  logic  scl_s, scl_rise, scl_fall;
  logic  shot, tog, shift_en, count_en, start_evt;

  serx_sync #(.STAGES(SYNC_STAGES)) u_sync_sda (
    .clk(clk), .rst(rst), .pin_i(sda_pin_i),
    .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  serx_sync #(.STAGES(SYNC_STAGES)) u_sync_scl (
    .clk(clk), .rst(rst), .pin_i(scl_pin_i),
    .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  assign shot      = ctl_wr_i & ctl_wdata_i[CTL_SHOT_BIT];
  assign tog       = ctl_wr_i & ctl_wdata_i[CTL_TOG_BIT];
  assign start_evt = sda_fall & scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
    end else if (ctl_wr_i) begin
      mode_q.src     <= src_e'(ctl_wdata_i[1:0]);
      mode_q.strb    <= ctl_wdata_i[CTL_STRB_BIT];
      mode_q.hold_en <= ctl_wdata_i[CTL_HOLD_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                            start_q <= 1'b0;
    else if (start_evt)                                 start_q <= 1'b1;
    else if (stat_wr_i && stat_wdata_i[START_CLR_BIT]) start_q <= 1'b0;
  end

  serx_clk_sel u_sel (
    .mode_i(mode_q), .ext_rise_i(scl_rise), .ext_fall_i(scl_fall),
    .tmr_i(tmr_match_i), .shot_i(shot), .tog_i(tog),
    .shift_en_o(shift_en), .count_en_o(count_en)
  );

  serx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(dat_wr_i), .load_data_i(dat_wdata_i),
    .shift_i(shift_en), .sdi_i(sda_s), .data_o(dat_o), .sdo_o(sdo_o)
  );

  serx_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clear_i(start_evt),
    .load_i(stat_wr_i), .load_val_i(stat_wdata_i[CNT_W-1:0]),
    .step_i(count_en),
    .flag_clr_i(stat_wr_i & stat_wdata_i[OVF_CLR_BIT]),
    .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  assign start_o    = start_q;
  assign scl_hold_o = ovf_o & mode_q.hold_en;
endmodule

// File: rtl/serx_core_chk.sv
module serx_core_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        src,
  input logic              tmr_match_i,
  input logic              stat_wr_i,
  input logic [CNT_W+1:0]  stat_wdata_i,
  input logic              dat_wr_i,
  input logic              start_evt,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              ovf_o,
  input logic              start_o,
  input logic [DATA_W-1:0] dat_o,
  input logic              strb
);
  // R2: no clock source leaves the data register untouched
  p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
    (src == 2'b00 && !strb && !dat_wr_i) |=> $stable(dat_o));

  // R4: timer pulse steps the counter
  p_timer_step_r4: assert property (@(posedge clk) disable iff (rst)
    (src == 2'b01 && tmr_match_i && !stat_wr_i && !start_evt)
      |=> cnt_o == CNT_W'($past(cnt_o) + 1));

  // R9: overflow rises only on a wrap to zero
  p_ovf_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> (cnt_o == '0));

  // R9: overflow falls only through a status clear write
  p_ovf_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_o) |-> $past(stat_wr_i && stat_wdata_i[CNT_W]));

  // R12: start flag rise comes with a zeroed counter
  p_start_zero_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(start_o) |-> (cnt_o == '0));
endmodule

bind serx_core serx_core_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .src(mode_q.src), .tmr_match_i(tmr_match_i),
  .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i), .dat_wr_i(dat_wr_i),
  .start_evt(start_evt), .cnt_o(cnt_o), .ovf_o(ovf_o), .start_o(start_o),
  .dat_o(dat_o), .strb(mode_q.strb)
);

// File: tb/serx_core_tb.sv
module serx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sda = 1'b1, scl = 1'b1, tmr = 1'b0;
  logic       ctl_wr = 1'b0, stat_wr = 1'b0, dat_wr = 1'b0;
  logic [5:0] ctl_d = '0, stat_d = '0;
  logic [7:0] dat_d = '0;
  logic       sdo, hold, ovf, start;
  logic [3:0] cnt;
  logic [7:0] dat;
  int         n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  serx_core dut_i (
    .clk(clk), .rst(rst), .sda_pin_i(sda), .scl_pin_i(scl), .tmr_match_i(tmr),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_d), .stat_wr_i(stat_wr),
    .stat_wdata_i(stat_d), .dat_wr_i(dat_wr), .dat_wdata_i(dat_d),
    .sdo_o(sdo), .scl_hold_o(hold), .ovf_o(ovf), .start_o(start),
    .cnt_o(cnt), .dat_o(dat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_d = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_stat(input logic [5:0] v);
    @(negedge clk); stat_wr = 1'b1; stat_d = v;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_d = v;
    @(negedge clk); dat_wr = 1'b0;
  endtask

  task automatic pulse_tmr;
    @(negedge clk); tmr = 1'b1;
    @(negedge clk); tmr = 1'b0;
  endtask

  task automatic set_scl(input logic v);
    @(negedge clk); scl = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic set_sda(input logic v);
    @(negedge clk); sda = v;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 dat", dat, 0); chk("R1 cnt", cnt, 0);
    chk("R1 ovf", ovf, 0); chk("R1 start", start, 0); chk("R1 hold", hold, 0);
  endtask

  task automatic t_none;
    wr_dat(8'hA5); wr_stat(6'h00);
    set_scl(1'b0); set_scl(1'b1); set_scl(1'b0);
    pulse_tmr(); wr_ctl(6'b001000);
    chk("R2 none dat", dat, 8'hA5); chk("R2 none cnt", cnt, 0);
  endtask

  task automatic t_soft;
    wr_ctl(6'b000100); wr_dat(8'h00); wr_stat(6'h00);
    wr_ctl(6'b001100); wr_ctl(6'b001100);
    chk("R3 soft dat", dat, 8'h03); chk("R3 soft cnt", cnt, 2);
  endtask

  task automatic t_timer;
    wr_ctl(6'b000101); wr_dat(8'hFF); wr_stat(6'h00);
    set_sda(1'b0);
    pulse_tmr(); pulse_tmr(); pulse_tmr();
    wr_ctl(6'b001101);
    chk("R4 timer dat", dat, 8'hF8); chk("R4 timer cnt", cnt, 3);
    chk("R11 sdo", sdo, 1);
  endtask

  task automatic t_pos;
    wr_ctl(6'b000010); set_sda(1'b1); wr_dat(8'h00); wr_stat(6'h00);
    for (int i = 0; i < 3; i++) begin set_scl(1'b1); set_scl(1'b0); end
    chk("R5 pos dat", dat, 8'h07); chk("R5 pos cnt", cnt, 6);
  endtask

  task automatic t_neg;
    wr_ctl(6'b000011); set_sda(1'b0); wr_dat(8'hFF); wr_stat(6'h00);
    set_scl(1'b1);
    chk("R6 rise no shift", dat, 8'hFF);
    set_scl(1'b0); set_scl(1'b1); set_scl(1'b0);
    chk("R6 neg dat", dat, 8'hFC); chk("R6 neg cnt", cnt, 4);
  endtask

  task automatic t_extstrb;
    wr_ctl(6'b000110); set_sda(1'b1); wr_dat(8'h00); wr_stat(6'h00);
    set_scl(1'b1); set_scl(1'b0);
    chk("R7 shift", dat, 8'h01); chk("R7 no pin count", cnt, 0);
    wr_ctl(6'b010110); wr_ctl(6'b010110);
    chk("R7 toggle count", cnt, 2);
  endtask

  task automatic t_ovf;
    wr_ctl(6'b100001); wr_stat(6'h0E);
    chk("R8 preload", cnt, 14);
    pulse_tmr();
    chk("R9 no ovf at 15", ovf, 0);
    pulse_tmr();
    chk("R9 wrap cnt", cnt, 0); chk("R9 ovf set", ovf, 1);
    chk("R10 hold set", hold, 1);
    wr_stat(6'h00);
    chk("R9 ovf sticky", ovf, 1);
    wr_stat(6'h10);
    chk("R9 ovf clr", ovf, 0); chk("R10 hold clr", hold, 0);
    wr_ctl(6'b000001); wr_stat(6'h0F); pulse_tmr();
    chk("R10 hold gated", hold, 0); chk("R10 ovf", ovf, 1);
    wr_stat(6'h10);
  endtask

  task automatic t_msb;
    wr_dat(8'h80); chk("R11 sdo hi", sdo, 1);
    wr_dat(8'h7F); chk("R11 sdo lo", sdo, 0);
  endtask

  task automatic t_start;
    wr_ctl(6'b000000); set_sda(1'b1); set_scl(1'b1); wr_stat(6'h05);
    set_sda(1'b0);
    chk("R12 start flag", start, 1); chk("R12 cnt clr", cnt, 0);
    wr_stat(6'h20);
    chk("R12 start clr", start, 0);
  endtask

  initial begin
    #4ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0x1 expected=0x0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset(); t_none(); t_soft(); t_timer(); t_pos();
    t_neg(); t_extstrb(); t_ovf(); t_msb(); t_start();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule